// File: doc/BRIEF.md
# Receive Line Quiet-Period Detector

This block sits beside a serial receiver and reports when the receive side has stayed quiet for a programmable number of bit periods. It takes a one-cycle bit-period pulse from the baud generator, the raw receive pin and a flag from the frame receiver that says its state machine is idle. A gate in front of the logic holds the line high until software lets the pin through. The gated level is also handed on to the frame receiver.

Software chooses what counts as quiet: either the gated line sitting at logic one, or the frame receiver resting in its idle state. Once an unbroken quiet stretch reaches the programmed threshold, a sticky flag is raised. Software clears it with a one-cycle write-one-to-clear strobe. The interrupt output is the flag qualified by its own enable. The quiet counter is needed when reception is filtered by address match, because that mode relies on idle detection.

Top module: `rx_idle_detector`

## Requirements
- R1: `rx_gated` equals `rx_pin` while `cfg_rx_gate_en` is 1. It is forced to 1 while `cfg_rx_gate_en` is 0.
- R2: With `cfg_idle_sel` = 0, the receive side counts as quiet while `rx_gated` is 1. A low pin that is held back by the gate therefore still counts as quiet.
- R3: With `cfg_idle_sel` = 1, the receive side counts as quiet while `rx_fsm_idle` is 1, and the line level has no effect.
- R4: `cfg_threshold` is counted in `bit_tick` pulses, not clock cycles. `idle_flag` reads 1 in the cycle after the tick that completes `cfg_threshold` ticks of an unbroken quiet period.
- R5: Any cycle that is not quiet restarts the tick count from zero.
- R6: The flag is raised at most once per quiet period. After a clear, it is not raised again until a non-quiet cycle has been followed by a new full quiet period.
- R7: A threshold of 0 never raises the flag.
- R8: While `cfg_detect_en` is 0, the tick count is held at zero and the flag is never raised. After enabling, a full threshold of ticks is needed.
- R9: A 1 on `flag_clr` drops the flag in the next cycle. When a raise and a clear fall in the same cycle, the raise wins.
- R10: `idle_irq` is 1 exactly when `idle_flag` and `irq_en` are both 1.
- R11: After reset, `idle_flag` and `idle_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| rx_pin | input | 1 | Raw receive pin level |
| rx_fsm_idle | input | 1 | Frame receiver state machine is idle |
| cfg_rx_gate_en | input | 1 | 1 passes the pin, 0 holds the line high |
| cfg_idle_sel | input | 1 | 0: quiet means line high; 1: quiet means receiver idle |
| cfg_detect_en | input | 1 | Enables quiet-period counting |
| cfg_threshold | input | THR_W | Quiet period length in bit periods, 0 disables raising |
| irq_en | input | 1 | Interrupt enable for the flag |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| rx_gated | output | 1 | Gated line level for the frame receiver |
| idle_flag | output | 1 | Sticky quiet-period flag |
| idle_irq | output | 1 | Qualified interrupt |

## Verification
Two things can happen in the same cycle: the flag being raised by the tick that completes the threshold, and a software clear strobe. The bench forces this directly by asserting `flag_clr` on the very tick that completes a two-tick quiet period. The random phase also produces the overlap from time to time, with clear strobes scattered over short thresholds. In both cases the expected result is that the flag stays high after that edge, and a reference model that gives the raise priority judges every random cycle the same way.

// File: rtl/rxidle_pkg.sv
package rxidle_pkg;

    typedef enum logic {
        COND_LINE_HIGH = 1'b0,
        COND_FSM_IDLE  = 1'b1
    } idle_cond_e;

endpackage

// File: rtl/rxidle_front.sv
module rxidle_front
    import rxidle_pkg::*;
(
    input  logic rx_pin,
    input  logic gate_en,
    input  logic idle_sel,
    input  logic fsm_idle,
    output logic rx_gated,
    output logic quiet
);

    idle_cond_e cond_mode;

    always_comb begin
        cond_mode = idle_cond_e'(idle_sel);
        // Hold the line high until the pin is released to the receiver.
        rx_gated  = gate_en ? rx_pin : 1'b1;
        case (cond_mode)
            COND_FSM_IDLE:  quiet = fsm_idle;
            default:        quiet = rx_gated;
        endcase
    end

endmodule

// File: rtl/rxidle_counter.sv
module rxidle_counter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             quiet,
    input  logic             detect_en,
    input  logic [THR_W-1:0] threshold,
    output logic             hit
);

    localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};
    localparam logic [THR_W:0]   ONE_EXT = {{THR_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [THR_W-1:0] cnt;
        logic             fired;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [THR_W:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        hit      = 1'b0;
        next_cnt = {1'b0, st_q.cnt} + ONE_EXT;
        if (!detect_en || !quiet) begin
            // Any busy cycle or disable restarts the quiet period.
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (bit_tick && !st_q.fired) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = next_cnt[THR_W-1:0];
            end
            if ((threshold != '0) && (next_cnt >= {1'b0, threshold})) begin
                st_d.fired = 1'b1;
                hit        = rst_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_SHOT_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R6

    AST_BUSY_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> (st_q.cnt == '0) && !st_q.fired); // R5

    AST_DISABLE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_en |=> (st_q.cnt == '0)); // R8

endmodule

// File: rtl/rxidle_flag.sv
module rxidle_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
        flag = st_q.flag;
        irq  = st_q.flag & irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(hit)); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !st_q.flag); // R9

    AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.flag); // R9

endmodule

// File: rtl/rx_idle_detector.sv
module rx_idle_detector #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             rx_pin,
    input  logic             rx_fsm_idle,
    input  logic             cfg_rx_gate_en,
    input  logic             cfg_idle_sel,
    input  logic             cfg_detect_en,
    input  logic [THR_W-1:0] cfg_threshold,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             rx_gated,
    output logic             idle_flag,
    output logic             idle_irq
);

    logic quiet;
    logic hit;

    rxidle_front i_front (
        .rx_pin   (rx_pin),
        .gate_en  (cfg_rx_gate_en),
        .idle_sel (cfg_idle_sel),
        .fsm_idle (rx_fsm_idle),
        .rx_gated (rx_gated),
        .quiet    (quiet)
    );

    rxidle_counter #(.THR_W(THR_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .quiet     (quiet),
        .detect_en (cfg_detect_en),
        .threshold (cfg_threshold),
        .hit       (hit)
    );

    rxidle_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (idle_flag),
        .irq    (idle_irq)
    );

    AST_ZERO_THR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_threshold == '0) |=> !$rose(idle_flag)); // R7

    AST_DISABLED_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_detect_en |=> !$rose(idle_flag)); // R8

    AST_NO_TICK_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> !$rose(idle_flag)); // R4

endmodule

// File: tb/test_rx_idle_detector.sv
`timescale 1ns/1ps
module test_rx_idle_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_pin = 1'b1;
    logic       rx_fsm_idle = 1'b1;
    logic       cfg_rx_gate_en = 1'b1;
    logic       cfg_idle_sel = 1'b0;
    logic       cfg_detect_en = 1'b1;
    logic [7:0] cfg_threshold = 8'd3;
    logic       irq_en = 1'b1;
    logic       flag_clr = 1'b0;
    logic       rx_gated, idle_flag, idle_irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  m_cnt   = 0;
    bit  m_fired = 1'b0;
    bit  m_flag  = 1'b0;

    always #5 clk = ~clk;

    rx_idle_detector #(.THR_W(8)) i_rx_idle_detector (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_pin(rx_pin),
        .rx_fsm_idle(rx_fsm_idle), .cfg_rx_gate_en(cfg_rx_gate_en),
        .cfg_idle_sel(cfg_idle_sel), .cfg_detect_en(cfg_detect_en),
        .cfg_threshold(cfg_threshold), .irq_en(irq_en), .flag_clr(flag_clr),
        .rx_gated(rx_gated), .idle_flag(idle_flag), .idle_irq(idle_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements, advanced once per clock.
    task automatic model_step();
        bit q;
        bit hit;
        int nc;
        hit = 1'b0;
        q = cfg_idle_sel ? rx_fsm_idle : (cfg_rx_gate_en ? rx_pin : 1'b1);
        if (!cfg_detect_en || !q) begin
            m_cnt = 0;
            m_fired = 1'b0;
        end else if (bit_tick && !m_fired) begin
            nc = m_cnt + 1;
            if (cfg_threshold != 0 && nc >= int'(cfg_threshold)) begin
                hit = 1'b1;
                m_fired = 1'b1;
            end
            m_cnt = (nc > 255) ? 255 : nc;
        end
        if (hit) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
    endtask

    task automatic cyc(input logic tk);
        bit_tick = tk;
        model_step();
        @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1);
            cyc(1'b0);
        end
    endtask

    // One busy cycle on the line together with a clear strobe.
    task automatic restart();
        rx_pin = 1'b0;
        flag_clr = 1'b1;
        cyc(1'b0);
        rx_pin = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1D1E));
        repeat (3) @(negedge clk);
        chk("R11 flag after reset", idle_flag, 1'b0);
        chk("R11 irq after reset", idle_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        irq_en = 1'b0;

        // R4: threshold of three ticks, free-running clock cycles do not count
        ticks(2);
        repeat (10) cyc(1'b0);
        chk("R4 below threshold", idle_flag, 1'b0);
        ticks(1);
        chk("R4 threshold reached", idle_flag, 1'b1);
        chk("R10 irq masked", idle_irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk("R10 irq enabled", idle_irq, 1'b1);

        // R9: clear strobe
        flag_clr = 1'b1;
        cyc(1'b0);
        chk("R9 clear", idle_flag, 1'b0);
        chk("R10 irq after clear", idle_irq, 1'b0);

        // R6: no second raise in the same quiet period
        ticks(10);
        chk("R6 no re-raise", idle_flag, 1'b0);
        rx_pin = 1'b0;
        #1;
        chk("R1 pin passes low", rx_gated, 1'b0);
        cyc(1'b0);
        rx_pin = 1'b1;
        ticks(3);
        chk("R6 raise after new period", idle_flag, 1'b1);

        // R5: busy cycle restarts the count
        cfg_threshold = 8'd4;
        restart();
        ticks(3);
        rx_pin = 1'b0;
        cyc(1'b0);
        rx_pin = 1'b1;
        ticks(3);
        chk("R5 count restarted", idle_flag, 1'b0);
        ticks(1);
        chk("R5 full period after restart", idle_flag, 1'b1);

        // R9: raise and clear in the same cycle
        cfg_threshold = 8'd2;
        restart();
        ticks(1);
        flag_clr = 1'b1;
        cyc(1'b1);
        chk("R9 raise wins over clear", idle_flag, 1'b1);

        // R7: zero threshold
        cfg_threshold = 8'd0;
        restart();
        ticks(20);
        chk("R7 zero threshold", idle_flag, 1'b0);

        // R8: detection disabled
        cfg_threshold = 8'd2;
        cfg_detect_en = 1'b0;
        ticks(5);
        chk("R8 disabled", idle_flag, 1'b0);
        cfg_detect_en = 1'b1;
        ticks(1);
        chk("R8 count held at zero", idle_flag, 1'b0);
        ticks(1);
        chk("R8 enabled raise", idle_flag, 1'b1);

        // R1 and R2: closed gate holds the line high
        restart();
        cfg_rx_gate_en = 1'b0;
        rx_pin = 1'b0;
        #1;
        chk("R1 gate forces high", rx_gated, 1'b1);
        ticks(2);
        chk("R2 gated low pin counts quiet", idle_flag, 1'b1);

        // R3: receiver idle selects, line ignored
        cfg_rx_gate_en = 1'b1;
        rx_pin = 1'b1;
        cfg_idle_sel = 1'b1;
        rx_fsm_idle = 1'b0;
        flag_clr = 1'b1;
        cyc(1'b0);
        ticks(5);
        chk("R3 busy receiver with high line", idle_flag, 1'b0);
        rx_fsm_idle = 1'b1;
        rx_pin = 1'b0;
        ticks(2);
        chk("R3 idle receiver with low line", idle_flag, 1'b1);

        // Random phase against the reference model
        for (int i = 0; i < 5000; i++) begin
            logic tk;
            rx_pin         = ($urandom_range(0, 9) != 0);
            rx_fsm_idle    = ($urandom_range(0, 7) != 0);
            cfg_rx_gate_en = ($urandom_range(0, 5) != 0);
            cfg_idle_sel   = ($urandom_range(0, 3) == 0);
            cfg_detect_en  = ($urandom_range(0, 15) != 0);
            irq_en         = ($urandom_range(0, 3) != 0);
            flag_clr       = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 49) == 0) cfg_threshold = 8'($urandom_range(0, 5));
            tk = ($urandom_range(0, 2) == 0);
            #1;
            chk("R1 random gate", rx_gated, cfg_rx_gate_en ? rx_pin : 1'b1);
            cyc(tk);
            chk("R4 random flag", idle_flag, m_flag);
            chk("R10 random irq", idle_irq, m_flag & irq_en);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule